// File: doc/BRIEF.md
# Six-Digit Multiplexed Decimal Display Driver

This block drives a six-position common-anode seven-segment display from a packed BCD value. Only one digit position is lit at a time. A scan state machine steps through the positions and stays on each for `DWELL` clocks. A `DWELL` of a few tens of thousands of system clocks gives each digit a refresh of roughly 1 kHz. For the position being shown, the block outputs the active-low segment pattern of that position's BCD digit.

Zeros to the left of the most significant non-zero digit stay dark. A value of 1000 therefore lights four positions, not six. A value of zero still shows a single `0` in the least significant position.

The scan state machine has six states, `SCAN_D0` to `SCAN_D5`. State `SCAN_Dn` selects digit position n, where position 0 is the least significant. The transitions are:
- `SCAN_D0`→`SCAN_D1`, `SCAN_D1`→`SCAN_D2`, `SCAN_D2`→`SCAN_D3`, `SCAN_D3`→`SCAN_D4` and `SCAN_D4`→`SCAN_D5` are taken on a dwell tick.
- `SCAN_D5`→`SCAN_D0` (wrap) is taken on a dwell tick.
- Without a tick, every state holds.
- Reset forces `SCAN_D0`.

Top module: `bcd_display_scanner`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next clock edge drives every enable and every segment line high.
- R2: After reset, positions are visited in the order 0,1,2,3,4,5, then back to 0. Each position is held for exactly `DWELL` clocks.
- R3: Segments are active low on `seg_n[6:0]` = g,f,e,d,c,b,a. The patterns are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.
- R4: A digit code from 10 to 15 drives all segments high (1111111). The enable of that position is still driven low, unless that position is blanked.
- R5: At most one bit of `digit_en_n` is low at any time. Enable bit n (active low) belongs to position n.
- R6: A position n>0 is blanked when it and every more significant digit are code 0. While a blanked position is selected, all enables and all segments are high.
- R7: When the whole value is zero, position 0 is still lit and shows the pattern for 0.
- R8: Zero digits below the most significant non-zero digit are shown as 0.
- R9: Outputs are registered. The outputs after a clock edge reflect the position selected before that edge and the `bcd_value` sampled at that edge. Position n is `bcd_value[4n+3:4n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_value | input | 24 | Six packed BCD digits, position n in bits 4n+3..4n |
| digit_en_n | output | 6 | Active-low digit enables, bit n selects position n |
| seg_n | output | 7 | Active-low segments, bit 6 = g down to bit 0 = a |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the scan counter and state register start from known values. They also assume that `bcd_value` never carries X or Z. The bench holds reset across the first edges and drives `bcd_value` with defined values only, changing them on the falling edge. The bench also applies non-decimal codes and changes the value while a digit is being shown. These patterns stress the blanking and decoding paths without leaving that assumed input space.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int NUM_DIGITS = 6;
    localparam int DIGIT_W    = 4;
    localparam int SEG_W      = 7;
    localparam int VALUE_W    = NUM_DIGITS * DIGIT_W;
    localparam int POS_W      = $clog2(NUM_DIGITS);

    typedef enum logic [POS_W-1:0] {
        SCAN_D0 = 3'd0,
        SCAN_D1 = 3'd1,
        SCAN_D2 = 3'd2,
        SCAN_D3 = 3'd3,
        SCAN_D4 = 3'd4,
        SCAN_D5 = 3'd5
    } scan_state_t;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;
    typedef logic [SEG_W-1:0]   seg_pat_t;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int DWELL = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;

    logic [CW-1:0] count_q;

    assign tick = (count_q == CW'(DWELL - 1));

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (tick) count_q <= '0;
        else           count_q <= count_q + 1'b1;
    end

    // R2: the dwell counter never leaves its window
    assert_dwell_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(count_q) < DWELL);
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    output logic [POS_W-1:0]      pos,
    output logic [NUM_DIGITS-1:0] select
);
    scan_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SCAN_D0: state_d = SCAN_D1;
                SCAN_D1: state_d = SCAN_D2;
                SCAN_D2: state_d = SCAN_D3;
                SCAN_D3: state_d = SCAN_D4;
                SCAN_D4: state_d = SCAN_D5;
                SCAN_D5: state_d = SCAN_D0;
                default: state_d = SCAN_D0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCAN_D0;
        else     state_q <= state_d;
    end

    always_comb begin
        pos    = POS_W'(state_q);
        select = '0;
        unique case (state_q)
            SCAN_D0: select[0] = 1'b1;
            SCAN_D1: select[1] = 1'b1;
            SCAN_D2: select[2] = 1'b1;
            SCAN_D3: select[3] = 1'b1;
            SCAN_D4: select[4] = 1'b1;
            SCAN_D5: select[5] = 1'b1;
            default: select    = '0;
        endcase
    end

    // R2: position only moves on a dwell tick
    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_q));
endmodule

// File: rtl/digit_blanker.sv
module digit_blanker
    import scan_pkg::*;
(
    input  logic [VALUE_W-1:0]    value,
    output logic [NUM_DIGITS-1:0] blank
);
    logic [NUM_DIGITS:0] upper_zero;

    assign upper_zero[NUM_DIGITS] = 1'b1;

    for (genvar i = NUM_DIGITS - 1; i >= 0; i--) begin : g_chain
        assign upper_zero[i] = upper_zero[i+1] && (value[i*DIGIT_W +: DIGIT_W] == '0);
        if (i == 0) begin : g_keep
            assign blank[i] = 1'b0;
        end else begin : g_lead
            assign blank[i] = upper_zero[i];
        end
    end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import scan_pkg::*;
(
    input  bcd_digit_t digit,
    output seg_pat_t   seg_n
);
    always_comb begin
        case (digit)
            4'd0:    seg_n = 7'b1000000;
            4'd1:    seg_n = 7'b1111001;
            4'd2:    seg_n = 7'b0100100;
            4'd3:    seg_n = 7'b0110000;
            4'd4:    seg_n = 7'b0011001;
            4'd5:    seg_n = 7'b0010010;
            4'd6:    seg_n = 7'b0000010;
            4'd7:    seg_n = 7'b1111000;
            4'd8:    seg_n = 7'b0000000;
            4'd9:    seg_n = 7'b0010000;
            default: seg_n = 7'b1111111;
        endcase
    end
endmodule

// File: rtl/bcd_display_scanner.sv
module bcd_display_scanner
    import scan_pkg::*;
#(
    parameter int DWELL = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [23:0] bcd_value,
    output logic [5:0]  digit_en_n,
    output logic [6:0]  seg_n
);
    logic                  tick;
    logic [POS_W-1:0]      pos;
    logic [NUM_DIGITS-1:0] select;
    logic [NUM_DIGITS-1:0] blank;
    bcd_digit_t            cur_digit;
    seg_pat_t              cur_pat;
    logic                  cur_blank;

    dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    scan_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .pos    (pos),
        .select (select)
    );

    digit_blanker u_blank (
        .value (bcd_value),
        .blank (blank)
    );

    assign cur_digit = bcd_value[int'(pos)*DIGIT_W +: DIGIT_W];
    assign cur_blank = blank[pos];

    seg_decoder u_dec (
        .digit (cur_digit),
        .seg_n (cur_pat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            digit_en_n <= '1;
            seg_n      <= '1;
        end else if (cur_blank) begin
            digit_en_n <= '1;
            seg_n      <= '1;
        end else begin
            digit_en_n <= ~select;
            seg_n      <= cur_pat;
        end
    end

    // R1: reset darkens the display on the following edge
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (digit_en_n == '1 && seg_n == '1));

    // R5: never two positions lit together
    assert_single_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~digit_en_n));

    // R6: with no position enabled the segment lines stay dark
    assert_dark_when_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (digit_en_n == '1) |-> (seg_n == '1));
endmodule

// File: tb/sim_bcd_display_scanner.sv
module sim_bcd_display_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int DWELL_T    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bcd_value = '0;
    logic [5:0]  digit_en_n;
    logic [6:0]  seg_n;

    int vectors = 0;
    int errors  = 0;

    // reference model state
    int         m_pos = 0;
    int         m_cnt = 0;
    logic [5:0] exp_en  = '1;
    logic [6:0] exp_seg = '1;
    string      exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_display_scanner #(.DWELL(DWELL_T)) u0 (
        .clk        (clk),
        .rst        (rst),
        .bcd_value  (bcd_value),
        .digit_en_n (digit_en_n),
        .seg_n      (seg_n)
    );

    function automatic logic [6:0] ref_seg(int d);
        case (d)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            3: return 7'b0110000;
            4: return 7'b0011001;
            5: return 7'b0010010;
            6: return 7'b0000010;
            7: return 7'b1111000;
            8: return 7'b0000000;
            9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    // behavioural reference, evaluated at each rising edge (R2, R9)
    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_cnt = 0;
            exp_en = '1; exp_seg = '1; exp_tag = "R1";
        end else begin
            int  d;
            bit  lead;
            d = int'(bcd_value[m_pos*4 +: 4]);
            lead = (m_pos != 0);
            for (int k = m_pos; k < 6; k++)
                if (bcd_value[k*4 +: 4] != 4'd0) lead = 0;
            if (lead) begin
                exp_en = '1; exp_seg = '1; exp_tag = "R6";
            end else begin
                exp_en = '1;
                exp_en[m_pos] = 1'b0;
                exp_seg = ref_seg(d);
                if (d > 9)                    exp_tag = "R4";
                else if (bcd_value == 24'd0)  exp_tag = "R7";
                else if (d == 0)              exp_tag = "R8";
                else                          exp_tag = "R3";
            end
            m_cnt = m_cnt + 1;
            if (m_cnt == DWELL_T) begin
                m_cnt = 0;
                m_pos = (m_pos + 1) % 6;
            end
        end
    end

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        vectors++;
        if (digit_en_n !== exp_en || seg_n !== exp_seg) begin
            errors++;
            $display("FAIL %s (R2/R9 scan) value=%h en=%b/%b seg=%b/%b (actual/expected)",
                     exp_tag, bcd_value, digit_en_n, exp_en, seg_n, exp_seg);
        end
        vectors++;
        if ($countones(~digit_en_n) > 1) begin
            errors++;
            $display("FAIL R5 en=%b expected at most one low", digit_en_n);
        end
    end

    task automatic show(input logic [23:0] v, input int cycles);
        @(negedge clk);
        bcd_value = v;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        show(24'h000000, 40);   // R7
        show(24'h001000, 40);   // R6, R8
        show(24'h123456, 40);   // R3
        show(24'h789000, 40);   // R3, R8
        show(24'h000007, 40);
        show(24'h0A0000, 40);   // R4 with leading blank
        show(24'h00F00B, 40);   // R4
        show(24'h100000, 40);
        show(24'h090807, 40);
        for (int i = 0; i < 30; i++) show(24'(i * 24'h011111), 7); // mid-scan changes
        @(negedge clk); rst = 1'b1;                                 // R1
        repeat (2) @(negedge clk); rst = 1'b0;
        show(24'h654321, 40);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule